// File: doc/BRIEF.md
# Compressor-Tree Unsigned Multiplier

This block multiplies two unsigned operands using only combinational logic. Its core is an 8-by-8 unit. The core ANDs every bit of one operand with every bit of the other to form eight partial-product rows. It collapses those rows to two in three reduction stages, which are built from rows of 4:2 compressor cells and rows of full-adder cells. A Kogge-Stone parallel prefix adder then sums the last two rows into the 16-bit product.

The top level produces a 32-bit product from two 16-bit operands. It splits each operand into a low byte and a high byte and feeds the four byte pairings to four copies of the core. The four partial products are aligned by 0, 8, 8 and 16 bits. One compressor row brings them down to two rows, and a 32-bit prefix adder adds those two rows.

The block has no clock, no reset and no state. The product follows the operands within the same evaluation, so a surrounding pipeline can place registers on either side as its timing requires.

Top module: `wtm_mul16`

## Requirements
- R1: `prod` equals the exact unsigned product of `op_a` and `op_b` for every operand pair. The product is 32 bits wide and nothing is truncated.
- R2: The 8-by-8 core returns the exact 16-bit unsigned product for all 65,536 operand pairs.
- R3: When either operand is zero, `prod` is zero.
- R4: When one operand is 1, `prod` equals the other operand zero-extended to 32 bits.
- R5: When both operands are 16'hFFFF, `prod` is 32'hFFFE0001. This is the largest result and sets every carry path.
- R6: `prod` is a pure function of the present operands. A change on the inputs appears at the output without any clock edge, and earlier inputs leave no trace.
- R7: When both operands have a zero upper byte, `prod[31:16]` is zero. When exactly one operand has only its upper byte set (bits 15:8) and the other has only its lower byte set, the product is the byte product shifted left by 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First unsigned operand |
| op_b | input | 16 | Second unsigned operand |
| prod | output | 32 | Unsigned product of op_a and op_b |

## Verification
The core receives every one of its 65,536 operand pairs. This exhaustive sweep covers every column pattern the compressor rows and the prefix carry tree can see, so a wrong cell equation or a miswired carry-out chain shows up on some pair. The 16-bit top is driven with a corner set and random pairs. The corner set crosses zero, one, all-ones, a lone top bit and each half on its own, and each corner isolates one byte pairing of the decomposition and its shift amount. The random pairs exercise the long carries through the 32-bit prefix adder. A direct input change between clock edges shows that the output has no hidden state.

// File: rtl/wtm_pkg.sv
package wtm_pkg;
    parameter int unsigned CORE_W  = 8;
    localparam int unsigned CORE_P = 2 * CORE_W;
    localparam int unsigned WIDE_W = 2 * CORE_W;
    localparam int unsigned WIDE_P = 2 * WIDE_W;

    typedef logic [CORE_P-1:0] core_row_t;
    typedef logic [WIDE_P-1:0] wide_row_t;

    // Reduction stages of the core, each a bundle of rows.
    typedef struct packed {
        core_row_t cmp_s;
        core_row_t cmp_c;
        core_row_t fa_s;
        core_row_t fa_c;
        core_row_t pass;
    } st1_t;

    typedef struct packed {
        core_row_t cmp_s;
        core_row_t cmp_c;
        core_row_t pass;
    } st2_t;

    typedef struct packed {
        core_row_t s;
        core_row_t c;
    } st3_t;
endpackage

// File: rtl/wtm_cmp42.sv
// Five-input column counter: s + 2*(c + co) = x1+x2+x3+x4+ci.
// co does not depend on ci, so a row of cells chains co into the next ci without rippling.
module wtm_cmp42 (
    input  logic x1,
    input  logic x2,
    input  logic x3,
    input  logic x4,
    input  logic ci,
    output logic s,
    output logic c,
    output logic co
);
    logic x12_d;
    logic x1234_d;

    always_comb begin
        x12_d   = x1 ^ x2;
        x1234_d = x12_d ^ x3 ^ x4;
        s       = x1234_d ^ ci;
        c       = x1234_d ? ci : x4;
        co      = x12_d ? x3 : x1;
    end
endmodule

// File: rtl/wtm_fa.sv
module wtm_fa (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic s,
    output logic co
);
    always_comb begin
        s  = a ^ b ^ c;
        co = (a & b) | (c & (a ^ b));
    end
endmodule

// File: rtl/wtm_cmp_row.sv
// Four rows in, two rows out, modulo 2^W. The top column only needs its sum bit.
module wtm_cmp_row #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] r0,
    input  logic [W-1:0] r1,
    input  logic [W-1:0] r2,
    input  logic [W-1:0] r3,
    output logic [W-1:0] s_row,
    output logic [W-1:0] c_row
);
    logic [W-1:0] chain_d;
    logic [W-2:0] cy_d;

    assign chain_d[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_col
        if (i < W - 1) begin : g_cell
            wtm_cmp42 u_cmp (
                .x1 (r0[i]),
                .x2 (r1[i]),
                .x3 (r2[i]),
                .x4 (r3[i]),
                .ci (chain_d[i]),
                .s  (s_row[i]),
                .c  (cy_d[i]),
                .co (chain_d[i+1])
            );
        end else begin : g_top
            assign s_row[i] = r0[i] ^ r1[i] ^ r2[i] ^ r3[i] ^ chain_d[i];
        end
    end

    assign c_row = {cy_d, 1'b0};
endmodule

// File: rtl/wtm_fa_row.sv
// Three rows in, two rows out, modulo 2^W.
module wtm_fa_row #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] r0,
    input  logic [W-1:0] r1,
    input  logic [W-1:0] r2,
    output logic [W-1:0] s_row,
    output logic [W-1:0] c_row
);
    logic [W-2:0] cy_d;

    for (genvar i = 0; i < W; i++) begin : g_col
        if (i < W - 1) begin : g_cell
            wtm_fa u_fa (
                .a  (r0[i]),
                .b  (r1[i]),
                .c  (r2[i]),
                .s  (s_row[i]),
                .co (cy_d[i])
            );
        end else begin : g_top
            assign s_row[i] = r0[i] ^ r1[i] ^ r2[i];
        end
    end

    assign c_row = {cy_d, 1'b0};
endmodule

// File: rtl/wtm_ks_add.sv
// Kogge-Stone sum of two rows modulo 2^W (no carry-in, carry-out not needed).
module wtm_ks_add #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    localparam int unsigned M  = W - 1;
    localparam int unsigned LV = $clog2(M);

    logic [W-1:0] prop_d;
    logic [M-1:0] g_d;
    logic [M-1:0] p_d;
    logic [M-1:0] g_n;
    logic [M-1:0] p_n;

    always_comb begin
        prop_d = a ^ b;
        g_d    = a[M-1:0] & b[M-1:0];
        p_d    = prop_d[M-1:0];
        for (int k = 0; k < LV; k++) begin
            g_n = g_d;
            p_n = p_d;
            for (int i = (1 << k); i < M; i++) begin
                g_n[i] = g_d[i] | (p_d[i] & g_d[i-(1<<k)]);
                p_n[i] = p_d[i] & p_d[i-(1<<k)];
            end
            g_d = g_n;
            p_d = p_n;
        end
        sum[0] = prop_d[0];
        for (int i = 1; i < W; i++) begin
            sum[i] = prop_d[i] ^ g_d[i-1];
        end
    end
endmodule

// File: rtl/wtm_core8.sv
// 8x8 core: AND array, three reduction stages, prefix adder.
module wtm_core8
    import wtm_pkg::*;
(
    input  logic [CORE_W-1:0] a,
    input  logic [CORE_W-1:0] b,
    output logic [CORE_P-1:0] p
);
    core_row_t pp_d [CORE_W];
    st1_t      st1_d;
    st2_t      st2_d;
    st3_t      st3_d;

    for (genvar r = 0; r < CORE_W; r++) begin : g_pp
        assign pp_d[r] = core_row_t'({CORE_W{b[r]}} & a) << r;
    end

    // Stage 1: rows 0-3 by compressors, rows 4-6 by full adders, row 7 waits.
    wtm_cmp_row #(.W(CORE_P)) u_s1_cmp (
        .r0 (pp_d[0]), .r1 (pp_d[1]), .r2 (pp_d[2]), .r3 (pp_d[3]),
        .s_row (st1_d.cmp_s), .c_row (st1_d.cmp_c)
    );
    wtm_fa_row #(.W(CORE_P)) u_s1_fa (
        .r0 (pp_d[4]), .r1 (pp_d[5]), .r2 (pp_d[6]),
        .s_row (st1_d.fa_s), .c_row (st1_d.fa_c)
    );
    assign st1_d.pass = pp_d[7];

    // Stage 2: four rows by compressors, one row waits.
    wtm_cmp_row #(.W(CORE_P)) u_s2_cmp (
        .r0 (st1_d.cmp_s), .r1 (st1_d.cmp_c), .r2 (st1_d.fa_s), .r3 (st1_d.fa_c),
        .s_row (st2_d.cmp_s), .c_row (st2_d.cmp_c)
    );
    assign st2_d.pass = st1_d.pass;

    // Stage 3: three rows by full adders.
    wtm_fa_row #(.W(CORE_P)) u_s3_fa (
        .r0 (st2_d.cmp_s), .r1 (st2_d.cmp_c), .r2 (st2_d.pass),
        .s_row (st3_d.s), .c_row (st3_d.c)
    );

    wtm_ks_add #(.W(CORE_P)) u_final (
        .a   (st3_d.s),
        .b   (st3_d.c),
        .sum (p)
    );
endmodule

// File: rtl/wtm_mul16.sv
// 16x16 product from four 8x8 cores, aligned and merged by one compressor row.
module wtm_mul16
    import wtm_pkg::*;
(
    input  logic [WIDE_W-1:0] op_a,
    input  logic [WIDE_W-1:0] op_b,
    output logic [WIDE_P-1:0] prod
);
    localparam int unsigned NPAIR = 4;

    logic [CORE_P-1:0] part_d [NPAIR];
    wide_row_t         row_d  [NPAIR];
    wide_row_t         mrg_s_d;
    wide_row_t         mrg_c_d;

    // Pair index bit 0 selects the half of op_a, bit 1 the half of op_b.
    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        localparam int unsigned HA = k % 2;
        localparam int unsigned HB = k / 2;
        wtm_core8 u_core (
            .a (op_a[HA*CORE_W +: CORE_W]),
            .b (op_b[HB*CORE_W +: CORE_W]),
            .p (part_d[k])
        );
        assign row_d[k] = wide_row_t'(part_d[k]) << ((HA + HB) * CORE_W);
    end

    wtm_cmp_row #(.W(WIDE_P)) u_merge (
        .r0 (row_d[0]), .r1 (row_d[1]), .r2 (row_d[2]), .r3 (row_d[3]),
        .s_row (mrg_s_d), .c_row (mrg_c_d)
    );

    wtm_ks_add #(.W(WIDE_P)) u_final (
        .a   (mrg_s_d),
        .b   (mrg_c_d),
        .sum (prod)
    );
endmodule

// File: rtl/wtm_mul16_chk.sv
module wtm_mul16_chk (
    input logic [15:0] op_a,
    input logic [15:0] op_b,
    input logic [31:0] prod
);
    always_comb begin
        AST_EXACT_PRODUCT: assert (prod == ({16'b0, op_a} * {16'b0, op_b})) // R1
            else $error("product mismatch");
        AST_ZERO_OPERAND: assert (!((op_a == 16'd0) || (op_b == 16'd0)) || (prod == 32'd0)) // R3
            else $error("zero operand gave nonzero product");
        AST_UNIT_OPERAND: assert (!(op_a == 16'd1) || (prod == {16'b0, op_b})) // R4
            else $error("unit operand not identity");
        AST_FULL_SCALE: assert (!((op_a == 16'hFFFF) && (op_b == 16'hFFFF)) || (prod == 32'hFFFE0001)) // R5
            else $error("full scale product wrong");
        AST_NARROW_HIGH: assert (!((op_a[15:8] == 8'd0) && (op_b[15:8] == 8'd0)) || (prod[31:16] == 16'd0)) // R7
            else $error("narrow operands set high half");
    end
endmodule

bind wtm_mul16 wtm_mul16_chk i_chk (
    .op_a (op_a),
    .op_b (op_b),
    .prod (prod)
);

// File: tb/test_wtm_mul16.sv
`timescale 1ns/1ps
module test_wtm_mul16;
    logic        clk = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [31:0] prod;
    logic [7:0]  c_a = '0;
    logic [7:0]  c_b = '0;
    logic [15:0] c_p;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    wtm_mul16 i_wtm_mul16 (.op_a(op_a), .op_b(op_b), .prod(prod));
    wtm_core8 i_core8 (.a(c_a), .b(c_b), .p(c_p));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, op_a, op_b, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_mul(input longint unsigned x, input longint unsigned y);
        longint unsigned r;
        r = x * y;
        return r[31:0];
    endfunction

    task automatic apply_top(input logic [15:0] x, input logic [15:0] y, input string req);
        @(posedge clk);
        #1;
        op_a = x;
        op_b = y;
        #2;
        chk(req, prod, ref_mul(x, y));
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        logic [15:0] corner [7];
        corner = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000, 16'h00FF, 16'hFF00, 16'h0100};

        // Reset-free start: zero inputs give zero (R3).
        #3;
        chk("R3", prod, 32'd0);

        // R2: exhaustive core sweep; R1/R7 on the top with the same narrow operands.
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                @(posedge clk);
                #1;
                c_a  = i[7:0];
                c_b  = j[7:0];
                op_a = {8'h00, i[7:0]};
                op_b = {8'h00, j[7:0]};
                #2;
                n_cmp++;
                if (c_p !== 16'(i * j)) begin
                    n_bad++;
                    $display("FAIL R2 a=%h b=%h actual=%h expected=%h", c_a, c_b, c_p, 16'(i * j));
                end
                chk("R7", {16'h0000, prod[31:16]}, 32'd0);
                chk("R1", prod, ref_mul(i, j));
            end
        end

        // Corner crossings on the top.
        for (int i = 0; i < 7; i++) begin
            for (int j = 0; j < 7; j++) begin
                apply_top(corner[i], corner[j], "R1");
            end
        end
        apply_top(16'h0000, 16'hBEEF, "R3");
        apply_top(16'h1234, 16'h0000, "R3");
        apply_top(16'h0001, 16'hCAFE, "R4");
        apply_top(16'hA5A5, 16'h0001, "R4");
        apply_top(16'hFFFF, 16'hFFFF, "R5");
        chk("R5", prod, 32'hFFFE0001);
        apply_top(16'h0100, 16'h00FF, "R7");
        chk("R7", prod, 32'h0000FF00);
        apply_top(16'h00C3, 16'h5A00, "R7");
        chk("R7", prod, 32'(16'h00C3 * 16'h005A) << 8);

        // R6: inputs change twice between edges; output tracks with no clock.
        @(negedge clk);
        op_a = 16'hFFFF;
        op_b = 16'h0003;
        #1;
        chk("R6", prod, 32'h0002FFFD);
        op_a = 16'h0002;
        op_b = 16'h0002;
        #1;
        chk("R6", prod, 32'h00000004);

        // Random pairs (R1).
        for (int n = 0; n < 2000; n++) begin
            apply_top(16'($urandom), 16'($urandom), "R1");
        end

        done = 1'b1;
        finish_run();
    end
endmodule